// File: doc/BRIEF.md
# IO Expansion Bus Strobe Sequencer

This block turns one host transfer request into a timed command sequence on an IO expansion bus. The bus carries a 4-bit command code, a set of chip-select lines and an 8-bit data path. A request names a read or a write, a target (generic IO port, IDE channel 1, IDE channel 2 or floppy controller), a chip-select pattern and write data. The block then steps through four phases: setup, strobe, hold and idle.

During setup the chip selects and any write data are already on the bus while the code stays at the all-ones idle value. The chip selects are therefore valid before any strobe is issued. The strobe phase drives the target's code for a fixed number of clocks, and a read samples the data bus on the last of those clocks. The hold phase returns the code to idle while the selects and write data stay in place. After the hold phase the block reports completion. A request that names a target value outside the four defined ones is refused with an error pulse and never reaches the bus.

Top module: `io_strobe_seq`

## Requirements
- R1: After reset, `code_o` is 4'b1111, `bus_oe_o` is 0, `csel_o` is 0, `req_ready_o` is 1, and `done_o` and `err_o` are 0.
- R2: In the strobe phase `code_o` has bit 3 set for a write and clear for a read. Bits 2:0 depend on the target: 3'b110 for generic IO (`req_target_i`=0), 3'b100 for IDE channel 1 (1), 3'b101 for IDE channel 2 (2) and 3'b011 for the floppy controller (3).
- R3: An accepted request is followed by exactly SETUP_CYC cycles with `code_o`=4'b1111, then exactly STROBE_CYC cycles of the target code, then HOLD_CYC idle cycles.
- R4: For a generic IO target, `csel_o` equals the requested pattern and stays stable from the first setup cycle through the last hold cycle. For every other target `csel_o` is 0.
- R5: For a write, `bus_oe_o` is 1 and `bus_dout_o` holds the write data from setup through hold. For a read, `bus_oe_o` stays 0.
- R6: For a read, `rdata_o` shows the value of `bus_din_i` sampled on the last strobe cycle, and it is valid when `done_o` is high.
- R7: A request with `req_target_i` in 4..7 gets a one-cycle `err_o` pulse in the cycle after acceptance. `code_o` stays 4'b1111, and `bus_oe_o` and `done_o` stay 0.
- R8: `code_o` is never 4'b0111 and never any value outside the eight command codes and 4'b1111.
- R9: `req_ready_o` is 0 from the cycle after acceptance until the sequence ends. `done_o` is a one-cycle pulse in the first cycle after hold, and `req_ready_o` is 1 in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Sequencer idle, request accepted when valid |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_target_i | input | 3 | Target: 0 generic IO, 1 IDE1, 2 IDE2, 3 floppy, 4..7 reserved |
| req_csel_i | input | CSEL_W | Chip-select pattern for generic IO |
| req_wdata_i | input | 8 | Write data |
| done_o | output | 1 | Sequence complete pulse |
| err_o | output | 1 | Reserved-target refusal pulse |
| rdata_o | output | 8 | Captured read data |
| code_o | output | 4 | Encoded bus command, 4'b1111 idle |
| csel_o | output | CSEL_W | Chip-select lines |
| bus_dout_o | output | 8 | Bus data out |
| bus_oe_o | output | 1 | Bus data output enable |
| bus_din_i | input | 8 | Bus data in |

## Verification
The assertions assume that `req_target_i`, `req_write_i`, `req_csel_i` and `req_wdata_i` matter only in the accepting cycle, and that `bus_din_i` is settled by the last strobe cycle. The stimulus drives a request for exactly one cycle while the sequencer is ready. It keeps `bus_din_i` constant from acceptance until completion and waits for `done_o` or `err_o` before issuing the next request. Every defined target is covered with both directions, and every reserved target value is tried at least once.

// File: rtl/io_seq_pkg.sv
package io_seq_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_STROBE, PH_HOLD} phase_e;

  localparam logic [3:0] CODE_IDLE = 4'b1111;

  localparam logic [2:0] TGT_GIO  = 3'd0;
  localparam logic [2:0] TGT_IDE1 = 3'd1;
  localparam logic [2:0] TGT_IDE2 = 3'd2;
  localparam logic [2:0] TGT_FDC  = 3'd3;
endpackage

// File: rtl/io_code_enc.sv
module io_code_enc
  import io_seq_pkg::*;
(
  input  logic [2:0] target_i,
  input  logic       write_i,
  output logic [3:0] code_o,
  output logic       legal_o,
  output logic       gio_o
);
  logic [2:0] sel;

  always_comb begin
    legal_o = 1'b1;
    unique case (target_i)
      TGT_GIO:  sel = 3'b110;
      TGT_IDE1: sel = 3'b100;
      TGT_IDE2: sel = 3'b101;
      TGT_FDC:  sel = 3'b011;
      default: begin
        sel     = 3'b111;
        legal_o = 1'b0;
      end
    endcase
    code_o = legal_o ? {write_i, sel} : CODE_IDLE;
    gio_o  = (target_i == TGT_GIO);
  end
endmodule

// File: rtl/io_phase_ctl.sv
module io_phase_ctl
  import io_seq_pkg::*;
#(
  parameter int unsigned SETUP_CYC  = 2,
  parameter int unsigned STROBE_CYC = 3,
  parameter int unsigned HOLD_CYC   = 1
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   start_i,
  output phase_e phase_o,
  output logic   last_strobe_o,
  output logic   done_o
);
  localparam int unsigned MAX_A = (SETUP_CYC > STROBE_CYC) ? SETUP_CYC : STROBE_CYC;
  localparam int unsigned MAX_LEN = (MAX_A > HOLD_CYC) ? MAX_A : HOLD_CYC;
  localparam int unsigned CNT_W = (MAX_LEN < 2) ? 1 : $clog2(MAX_LEN);

  localparam logic [CNT_W-1:0] SETUP_LD  = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] STROBE_LD = CNT_W'(STROBE_CYC - 1);
  localparam logic [CNT_W-1:0] HOLD_LD   = CNT_W'(HOLD_CYC - 1);

  phase_e           phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             done_q, done_d;
  logic             cnt_zero;

  assign cnt_zero = (cnt_q == '0);

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    done_d  = 1'b0;
    unique case (phase_q)
      PH_IDLE: if (start_i) begin
        phase_d = PH_SETUP;
        cnt_d   = SETUP_LD;
      end
      PH_SETUP: if (cnt_zero) begin
        phase_d = PH_STROBE;
        cnt_d   = STROBE_LD;
      end else cnt_d = cnt_q - 1'b1;
      PH_STROBE: if (cnt_zero) begin
        phase_d = PH_HOLD;
        cnt_d   = HOLD_LD;
      end else cnt_d = cnt_q - 1'b1;
      PH_HOLD: if (cnt_zero) begin
        phase_d = PH_IDLE;
        done_d  = 1'b1;
      end else cnt_d = cnt_q - 1'b1;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      done_q  <= done_d;
    end
  end

  assign phase_o       = phase_q;
  assign last_strobe_o = (phase_q == PH_STROBE) && cnt_zero;
  assign done_o        = done_q;

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q); // R9
  AST_DONE_AFTER_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_q) |-> $past(phase_q) == PH_HOLD); // R9
endmodule

// File: rtl/io_strobe_seq.sv
module io_strobe_seq
  import io_seq_pkg::*;
#(
  parameter int unsigned CSEL_W     = 4,
  parameter int unsigned SETUP_CYC  = 2,
  parameter int unsigned STROBE_CYC = 3,
  parameter int unsigned HOLD_CYC   = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [2:0]        req_target_i,
  input  logic [CSEL_W-1:0] req_csel_i,
  input  logic [7:0]        req_wdata_i,
  output logic              done_o,
  output logic              err_o,
  output logic [7:0]        rdata_o,
  output logic [3:0]        code_o,
  output logic [CSEL_W-1:0] csel_o,
  output logic [7:0]        bus_dout_o,
  output logic              bus_oe_o,
  input  logic [7:0]        bus_din_i
);
  localparam int unsigned RUN_W = $clog2(STROBE_CYC + 2);

  phase_e            phase;
  logic              last_strobe;
  logic              accept, start;
  logic [3:0]        enc_code;
  logic              enc_legal, enc_gio;
  logic [3:0]        code_q;
  logic              write_q, err_q;
  logic [CSEL_W-1:0] csel_q;
  logic [7:0]        wdata_q, rdata_q;

  io_code_enc u_enc (
    .target_i (req_target_i),
    .write_i  (req_write_i),
    .code_o   (enc_code),
    .legal_o  (enc_legal),
    .gio_o    (enc_gio)
  );

  io_phase_ctl #(
    .SETUP_CYC  (SETUP_CYC),
    .STROBE_CYC (STROBE_CYC),
    .HOLD_CYC   (HOLD_CYC)
  ) u_ctl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .start_i       (start),
    .phase_o       (phase),
    .last_strobe_o (last_strobe),
    .done_o        (done_o)
  );

  assign req_ready_o = (phase == PH_IDLE);
  assign accept      = req_valid_i && req_ready_o;
  assign start       = accept && enc_legal;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q  <= CODE_IDLE;
      write_q <= 1'b0;
      csel_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      err_q <= accept && !enc_legal;
      if (start) begin
        code_q  <= enc_code;
        write_q <= req_write_i;
        csel_q  <= enc_gio ? req_csel_i : '0;
        wdata_q <= req_wdata_i;
      end else if (done_o) begin
        csel_q  <= '0;
        write_q <= 1'b0;
      end
      if (last_strobe && !write_q) rdata_q <= bus_din_i;
    end
  end

  // selects and write data live from setup through hold
  logic active;
  assign active     = (phase != PH_IDLE);
  assign code_o     = (phase == PH_STROBE) ? code_q : CODE_IDLE;
  assign csel_o     = active ? csel_q : '0;
  assign bus_oe_o   = active && write_q;
  assign bus_dout_o = bus_oe_o ? wdata_q : '0;
  assign rdata_o    = rdata_q;
  assign err_o      = err_q;

  // run length of non-idle code for the strobe-width check
  logic [RUN_W-1:0] run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= '0;
    else if (code_o != CODE_IDLE) run_q <= run_q + 1'b1;
    else run_q <= '0;
  end

  AST_CODE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    code_o inside {4'b1111, 4'b1110, 4'b0110, 4'b1101, 4'b0101,
                   4'b1100, 4'b0100, 4'b1011, 4'b0011}); // R8
  AST_STROBE_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_o == CODE_IDLE && run_q != '0) |-> run_q == RUN_W'(STROBE_CYC)); // R3
  AST_CSEL_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_ready_o && !$past(req_ready_o)) |-> $stable(csel_o)); // R4
  AST_WDATA_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_oe_o && $past(bus_oe_o)) |-> $stable(bus_dout_o)); // R5
  AST_ERR_NO_BUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (code_o == CODE_IDLE && !bus_oe_o && !done_o)); // R7
  AST_BUSY_NOT_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_o != CODE_IDLE) |-> !req_ready_o); // R9
endmodule

// File: tb/tb_io_strobe_seq.sv
module tb_io_strobe_seq;
  localparam int CSEL_W = 4;
  localparam int SETUP_CYC = 2;
  localparam int STROBE_CYC = 4;
  localparam int HOLD_CYC = 2;

  typedef struct {
    logic              err;
    logic [3:0]        code;
    logic [CSEL_W-1:0] csel;
    logic              oe;
    logic [7:0]        dout;
    logic              is_read;
    logic [7:0]        rdata;
  } exp_t;

  logic clk = 0;
  logic rst_ni = 0;
  logic req_valid = 0, req_write = 0;
  logic [2:0] req_target = 0;
  logic [CSEL_W-1:0] req_csel = 0;
  logic [7:0] req_wdata = 0, bus_din = 0;
  logic req_ready, done, err, bus_oe;
  logic [7:0] rdata, bus_dout;
  logic [3:0] code;
  logic [CSEL_W-1:0] csel;

  int checks = 0, errors = 0;
  exp_t q[$];
  bit finished = 0;

  always #2.5 clk = ~clk;

  io_strobe_seq #(
    .CSEL_W(CSEL_W), .SETUP_CYC(SETUP_CYC), .STROBE_CYC(STROBE_CYC), .HOLD_CYC(HOLD_CYC)
  ) dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_write_i(req_write), .req_target_i(req_target), .req_csel_i(req_csel),
    .req_wdata_i(req_wdata), .done_o(done), .err_o(err), .rdata_o(rdata),
    .code_o(code), .csel_o(csel), .bus_dout_o(bus_dout), .bus_oe_o(bus_oe),
    .bus_din_i(bus_din)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] ref_code(input logic w, input logic [2:0] t);
    logic [2:0] lo;
    case (t)
      3'd0: lo = 3'b110;
      3'd1: lo = 3'b100;
      3'd2: lo = 3'b101;
      default: lo = 3'b011;
    endcase
    return {w, lo};
  endfunction

  // driver: push expectation, present request for one cycle, wait for end
  task automatic issue(input logic w, input logic [2:0] t, input logic [CSEL_W-1:0] cs,
                       input logic [7:0] wd, input logic [7:0] din);
    exp_t e;
    e.err = (t > 3'd3);
    e.code = ref_code(w, t);
    e.csel = (t == 3'd0) ? cs : '0;
    e.oe = w;
    e.dout = wd;
    e.is_read = !w;
    e.rdata = din;
    q.push_back(e);
    @(negedge clk);
    req_valid = 1; req_write = w; req_target = t; req_csel = cs; req_wdata = wd;
    bus_din = din;
    @(negedge clk);
    req_valid = 0; req_target = 3'd0; req_csel = '0; req_wdata = 8'h5A; req_write = ~w;
    if (!e.err) chk(req_ready == 0, "R9 ready low after accept", req_ready, 0);
    while (!(done || err)) @(negedge clk);
    @(negedge clk);
  endtask

  // monitor: observe bus per transaction, compare on completion
  int strobe_n = 0, setup_n = 0, hold_n = 0;
  logic [3:0] seen_code;
  logic [CSEL_W-1:0] seen_csel;
  logic seen_oe;
  logic [7:0] seen_dout;
  logic oe_bad = 0, csel_bad = 0;

  always @(negedge clk) if (rst_ni) begin
    if (!req_ready) begin
      if (code != 4'hF) begin
        strobe_n++;
        seen_code = code;
        if (strobe_n == 1) begin
          seen_csel = csel; seen_oe = bus_oe; seen_dout = bus_dout;
        end
      end else if (strobe_n == 0) setup_n++;
      else hold_n++;
      if (strobe_n > 0 && (csel != seen_csel)) csel_bad = 1;
      if (strobe_n > 0 && (bus_oe != seen_oe)) oe_bad = 1;
    end
    if (done || err) begin
      exp_t e;
      if (q.size() == 0) chk(0, "R9 unexpected completion", 1, 0);
      else begin
        e = q.pop_front();
        chk(err == e.err, "R7 err flag", err, e.err);
        chk(req_ready == 1, "R9 ready at completion", req_ready, 1);
        chk(!(done && err), "R7 done with err", done, 0);
        if (e.err) begin
          chk(strobe_n == 0, "R7 no strobe on reserved", strobe_n, 0);
          chk(code == 4'hF, "R7 code idle", code, 4'hF);
        end else begin
          chk(seen_code == e.code, "R2 strobe code", seen_code, e.code);
          chk(strobe_n == STROBE_CYC, "R3 strobe length", strobe_n, STROBE_CYC);
          chk(setup_n == SETUP_CYC, "R3 setup length", setup_n, SETUP_CYC);
          chk(hold_n == HOLD_CYC, "R3 hold length", hold_n, HOLD_CYC);
          chk(seen_csel == e.csel && !csel_bad, "R4 chip select", seen_csel, e.csel);
          chk(seen_oe == e.oe && !oe_bad, "R5 output enable", seen_oe, e.oe);
          if (e.oe) chk(seen_dout == e.dout, "R5 write data", seen_dout, e.dout);
          if (e.is_read) chk(rdata == e.rdata, "R6 read data", rdata, e.rdata);
        end
      end
      strobe_n = 0; setup_n = 0; hold_n = 0; csel_bad = 0; oe_bad = 0;
    end
  end

  // R8: code always in the legal set
  always @(negedge clk) if (rst_ni && !(code inside {4'hF, 4'hE, 4'h6, 4'hD, 4'h5, 4'hC, 4'h4, 4'hB, 4'h3}))
    chk(0, "R8 illegal code", code, 4'hF);

  initial begin
    #1000000;
    chk(0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(code == 4'hF, "R1 idle code", code, 4'hF);
    chk(bus_oe == 0 && csel == 0, "R1 bus quiet", {bus_oe, csel}, 0);
    chk(req_ready == 1 && done == 0 && err == 0, "R1 ready", {req_ready, done, err}, 3'b100);
    rst_ni = 1;
    repeat (2) @(negedge clk);
    chk(code == 4'hF && req_ready, "R1 idle after release", code, 4'hF);
    issue(1, 3'd0, 4'b1010, 8'hA5, 8'h00);
    issue(0, 3'd0, 4'b0110, 8'h00, 8'h3C);
    issue(1, 3'd1, 4'b1111, 8'h11, 8'h00);
    issue(0, 3'd1, 4'b1111, 8'h00, 8'hC3);
    issue(1, 3'd2, 4'b0001, 8'h22, 8'h00);
    issue(0, 3'd2, 4'b0001, 8'h00, 8'h7E);
    issue(1, 3'd3, 4'b1000, 8'hFF, 8'h00);
    issue(0, 3'd3, 4'b1000, 8'h00, 8'h81);
    for (int t = 4; t < 8; t++) issue(t[0], 3'(t), 4'b1111, 8'h99, 8'h00);
    issue(0, 3'd0, 4'b0011, 8'h00, 8'h00);
    issue(1, 3'd0, 4'b1100, 8'h00, 8'h00);
    repeat (3) @(negedge clk);
    chk(q.size() == 0, "R9 all completions seen", q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule